// File: doc/BRIEF.md
# IR Mark-Space Symbol Modulator

This block turns a stream of data words into an infrared transmit waveform. It takes each word from an upstream source through a valid/ready handshake and sends it one bit at a time, most significant bit first. Every bit becomes a symbol made of a mark part and a space part. Both parts are counted in whole carrier periods. During a mark the output carries a square-wave carrier. During a space the output rests at the idle level.

The carrier duty is set by two counts of IR clock cycles, one for the high time and one for the low time. Logic one and logic zero each have their own mark length and space length. Each also has its own order bit, which picks whether the symbol begins with the mark or with the space. An invert control flips the final pin polarity. All configuration arrives as plain inputs and must stay stable while the block is busy. A low enable returns the block to its reset state.

The block reports a busy flag and a one-cycle strobe at the end of each symbol. A new word presented while the last symbol of the current word finishes is taken with no gap, so the waveform continues without a break.

Top module: `ir_symbol_modulator`

## Requirements
- R1: A carrier period is the high count of cycles at level 1, then the low count of cycles at level 0. With a low count of 0 the carrier stays high through the whole mark.
- R2: A carrier high count of 0 acts as a high count of 1.
- R3: A bit of value 1 lasts `one_mark` carrier periods of mark plus `one_space` carrier periods of space. A bit of value 0 uses `zero_mark` and `zero_space` in the same way.
- R4: The order bit of the current symbol's value sets the part order. When it is 1 the space comes first, then the mark. When it is 0 the mark comes first, then the space.
- R5: During a space the pin holds the idle level, which is 0 before inversion. The carrier keeps counting through the space, so every symbol lasts exactly (mark+space)×(high+low) cycles.
- R6: With `invert` high, `ir_out` is the complement of the uninverted waveform in every state, idle included.
- R7: A word is accepted when `word_valid` and `word_ready` are both high at a clock edge. `word_ready` is high while enabled and either idle or in the last cycle of the word's last symbol. Bits go out most significant bit first, and there are no gap cycles between bits or between back-to-back words.
- R8: `busy` rises in the cycle after a word is accepted. It falls in the cycle after the final symbol ends, unless another word is accepted in that last cycle.
- R9: `sym_done` is high for exactly one cycle per symbol, in that symbol's final cycle.
- R10: When `enable` is low, `busy` is low from the next cycle, `word_ready` is low, and the pin is at the idle level. The next word after re-enabling starts from a fresh state.
- R11: A mark length or space length of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IR clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds the reset state |
| invert | input | 1 | Flip output polarity |
| car_high | input | CAR_W | Carrier high time in clock cycles |
| car_low | input | CAR_W | Carrier low time in clock cycles |
| one_mark | input | MARK_W | Logic-one mark length in carrier periods |
| one_space | input | SPACE_W | Logic-one space length in carrier periods |
| zero_mark | input | MARK_W | Logic-zero mark length in carrier periods |
| zero_space | input | SPACE_W | Logic-zero space length in carrier periods |
| one_space_first | input | 1 | Logic one: 1 = space then mark, 0 = mark then space |
| zero_space_first | input | 1 | Logic zero: 1 = space then mark, 0 = mark then space |
| word_data | input | WORD_W | Data word to send |
| word_valid | input | 1 | Word available |
| word_ready | output | 1 | Block takes the word at this edge |
| ir_out | output | 1 | Modulated IR output |
| busy | output | 1 | Symbols in progress |
| sym_done | output | 1 | Final cycle of a symbol |

## Verification
The bench builds the block with 4-bit words, 4-bit carrier counts, 4-bit mark lengths and 3-bit space lengths. With these widths every symbol fits in a few dozen cycles, so the bench can sweep all carrier high counts 0 to 2, all low counts 0 to 2, both polarities and all four order combinations. The sweep includes zero mark and space lengths. Each run sends two back-to-back words and compares the pin, busy, strobe and ready in every cycle against an arithmetic model. This covers the zero-count clamps, the continuous carrier that a low count of 0 gives, and the word-to-word handover edge. An enable drop in the middle of a word is exercised separately.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;

  typedef enum logic {
    PART_FIRST  = 1'b0,
    PART_SECOND = 1'b1
  } sym_part_e;

endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CAR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CAR_W-1:0] high_len,
  input  logic [CAR_W-1:0] low_len,
  output logic             car_level,
  output logic             period_end
);

  logic [CAR_W-1:0] cnt_q, cnt_d;
  logic             hi_q, hi_d;
  logic [CAR_W-1:0] hi_len;
  logic             hi_end, lo_end, no_low;

  always_comb begin
    hi_len     = (high_len == '0) ? CAR_W'(1) : high_len;
    no_low     = (low_len == '0);
    hi_end     = hi_q && (cnt_q == hi_len - CAR_W'(1));
    lo_end     = !hi_q && (cnt_q == low_len - CAR_W'(1));
    period_end = run && (lo_end || (hi_end && no_low));
    hi_d       = hi_q;
    cnt_d      = cnt_q;
    if (!run) begin
      hi_d  = 1'b1;
      cnt_d = '0;
    end else if (hi_end) begin
      cnt_d = '0;
      hi_d  = no_low;
    end else if (lo_end) begin
      cnt_d = '0;
      hi_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + CAR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  assign car_level = hi_q;

  AST_CAR_HI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hi_q) |-> (cnt_q < hi_len)); // R2
  AST_CAR_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && no_low) |-> hi_q); // R1

endmodule

// File: rtl/ir_symbol_timer.sv
module ir_symbol_timer
  import ir_mod_pkg::*;
#(
  parameter int MARK_W  = 16,
  parameter int SPACE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               period_end,
  input  logic               cur_bit,
  input  logic [MARK_W-1:0]  one_mark,
  input  logic [SPACE_W-1:0] one_space,
  input  logic [MARK_W-1:0]  zero_mark,
  input  logic [SPACE_W-1:0] zero_space,
  input  logic               one_space_first,
  input  logic               zero_space_first,
  output logic               mark_now,
  output logic               sym_end
);

  sym_part_e         part_q, part_d;
  logic [MARK_W-1:0] pcnt_q, pcnt_d;
  logic [MARK_W-1:0] mark_len, space_len, cur_len;
  logic              space_first, last_per;

  always_comb begin
    mark_len    = cur_bit ? one_mark : zero_mark;
    space_len   = cur_bit ? MARK_W'(one_space) : MARK_W'(zero_space);
    if (mark_len == '0)  mark_len  = MARK_W'(1);
    if (space_len == '0) space_len = MARK_W'(1);
    space_first = cur_bit ? one_space_first : zero_space_first;
    if (part_q == PART_FIRST) cur_len = space_first ? space_len : mark_len;
    else                      cur_len = space_first ? mark_len : space_len;
    last_per = (pcnt_q == cur_len - MARK_W'(1));
    mark_now = (part_q == PART_FIRST) ? !space_first : space_first;
    sym_end  = run && period_end && (part_q == PART_SECOND) && last_per;
    part_d   = part_q;
    pcnt_d   = pcnt_q;
    if (!run) begin
      part_d = PART_FIRST;
      pcnt_d = '0;
    end else if (period_end) begin
      if (last_per) begin
        pcnt_d = '0;
        part_d = (part_q == PART_FIRST) ? PART_SECOND : PART_FIRST;
      end else begin
        pcnt_d = pcnt_q + MARK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= PART_FIRST;
      pcnt_q <= '0;
    end else begin
      part_q <= part_d;
      pcnt_q <= pcnt_d;
    end
  end

  AST_PART_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pcnt_q < cur_len)); // R3
  AST_IDLE_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (part_q == PART_FIRST) && (pcnt_q == '0)); // R10

endmodule

// File: rtl/ir_bit_shifter.sv
module ir_bit_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              sym_end,
  output logic              cur_bit,
  output logic              last_bit,
  output logic              busy
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    if (!enable) begin
      sh_d   = '0;
      left_d = '0;
      busy_d = 1'b0;
    end else if (load) begin
      sh_d   = load_data;
      left_d = CNT_W'(WORD_W);
      busy_d = 1'b1;
    end else if (busy_q && sym_end) begin
      if (left_q == CNT_W'(1)) begin
        left_d = '0;
        busy_d = 1'b0;
      end else begin
        sh_d   = {sh_q[WORD_W-2:0], 1'b0};
        left_d = left_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign cur_bit  = sh_q[WORD_W-1];
  assign last_bit = (left_q == CNT_W'(1));
  assign busy     = busy_q;

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy_q); // R10
  AST_BITS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0)); // R7

endmodule

// File: rtl/ir_symbol_modulator.sv
module ir_symbol_modulator #(
  parameter int WORD_W  = 16,
  parameter int CAR_W   = 10,
  parameter int MARK_W  = 16,
  parameter int SPACE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               invert,
  input  logic [CAR_W-1:0]   car_high,
  input  logic [CAR_W-1:0]   car_low,
  input  logic [MARK_W-1:0]  one_mark,
  input  logic [SPACE_W-1:0] one_space,
  input  logic [MARK_W-1:0]  zero_mark,
  input  logic [SPACE_W-1:0] zero_space,
  input  logic               one_space_first,
  input  logic               zero_space_first,
  input  logic [WORD_W-1:0]  word_data,
  input  logic               word_valid,
  output logic               word_ready,
  output logic               ir_out,
  output logic               busy,
  output logic               sym_done
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       busy_w, cur_bit, last_bit, sym_end, mark_now;
  logic       car_level, period_end, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign word_ready = enable && (!busy_w || (sym_end && last_bit));
  assign accept     = word_valid && word_ready;

  ir_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n_int), .enable(enable), .load(accept),
    .load_data(word_data), .sym_end(sym_end), .cur_bit(cur_bit),
    .last_bit(last_bit), .busy(busy_w)
  );

  ir_carrier_gen #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_n_int), .run(busy_w), .high_len(car_high),
    .low_len(car_low), .car_level(car_level), .period_end(period_end)
  );

  ir_symbol_timer #(.MARK_W(MARK_W), .SPACE_W(SPACE_W)) u_sym (
    .clk(clk), .rst_n(rst_n_int), .run(busy_w), .period_end(period_end),
    .cur_bit(cur_bit), .one_mark(one_mark), .one_space(one_space),
    .zero_mark(zero_mark), .zero_space(zero_space),
    .one_space_first(one_space_first), .zero_space_first(zero_space_first),
    .mark_now(mark_now), .sym_end(sym_end)
  );

  assign ir_out   = invert ^ (busy_w & mark_now & car_level);
  assign busy     = busy_w;
  assign sym_done = sym_end;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && enable) |=> busy); // R8
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int)
    sym_done |-> busy); // R9
  AST_SPACE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (busy && !mark_now) |-> (ir_out == invert)); // R5
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy |-> (ir_out == invert)); // R6

endmodule

// File: tb/ir_symbol_modulator_test.sv
module ir_symbol_modulator_test;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 4;
  localparam int CW = 4;
  localparam int MW = 4;
  localparam int SW = 3;
  localparam int WATCHDOG = 150000;

  logic          clk, rst_n, enable, invert;
  logic [CW-1:0] car_high, car_low;
  logic [MW-1:0] one_mark, zero_mark;
  logic [SW-1:0] one_space, zero_space;
  logic          one_space_first, zero_space_first;
  logic [WW-1:0] word_data;
  logic          word_valid, word_ready, ir_out, busy, sym_done;

  int checks = 0;
  int fails  = 0;

  ir_symbol_modulator #(.WORD_W(WW), .CAR_W(CW), .MARK_W(MW), .SPACE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
    .car_high(car_high), .car_low(car_low), .one_mark(one_mark),
    .one_space(one_space), .zero_mark(zero_mark), .zero_space(zero_space),
    .one_space_first(one_space_first), .zero_space_first(zero_space_first),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .ir_out(ir_out), .busy(busy), .sym_done(sym_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Sends two back-to-back words and checks every cycle against the model.
  task automatic run_pair(input logic [WW-1:0] w0, input logic [WW-1:0] w1);
    logic [2*WW-1:0] seq;
    int hh, pp, mk, sp, a, b2, slen, pi, cc;
    bit bv, sf, mark, car, exp_out;
    seq = {w0, w1};
    hh  = (car_high == 0) ? 1 : int'(car_high);   // R2
    pp  = hh + int'(car_low);
    word_data  = w0;
    word_valid = 1'b1;
    chk(word_ready == 1'b1, "R7 ready when idle", word_ready, 1);
    @(posedge clk);
    @(negedge clk);
    word_data = w1;
    for (int s = 0; s < 2*WW; s++) begin
      bv = seq[2*WW-1-s];                          // R7 MSB first
      mk = bv ? int'(one_mark) : int'(zero_mark);
      sp = bv ? int'(one_space) : int'(zero_space);
      if (mk == 0) mk = 1;                         // R11
      if (sp == 0) sp = 1;
      sf = bv ? one_space_first : zero_space_first;
      a  = sf ? sp : mk;
      b2 = sf ? mk : sp;
      slen = (a + b2) * pp;                        // R3 R5
      for (int o = 0; o < slen; o++) begin
        pi   = o / pp;
        cc   = o % pp;
        car  = (cc < hh);                          // R1
        mark = (pi < a) ? !sf : sf;                // R4
        exp_out = invert ^ (mark & car);           // R6
        chk(ir_out == exp_out, mark ? "R1 R3 R4 mark waveform" : "R5 R4 space level",
            ir_out, exp_out);
        chk(busy == 1'b1, "R8 busy during symbols", busy, 1);
        chk(sym_done == (o == slen-1), "R9 symbol strobe", sym_done, (o == slen-1));
        chk(word_ready == ((o == slen-1) && (s == WW-1 || s == 2*WW-1)),
            "R7 ready only at word end", word_ready,
            ((o == slen-1) && (s == WW-1 || s == 2*WW-1)));
        @(negedge clk);
        if (s == WW-1 && o == slen-1) word_valid = 1'b0;
      end
    end
    chk(busy == 1'b0, "R8 busy falls after last symbol", busy, 0);
    chk(ir_out == invert, "R6 idle level", ir_out, invert);
    chk(sym_done == 1'b0, "R9 no strobe when idle", sym_done, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; invert = 1'b0;
    car_high = 4'd1; car_low = 4'd1;
    one_mark = 4'd1; one_space = 3'd1; zero_mark = 4'd1; zero_space = 3'd1;
    one_space_first = 1'b0; zero_space_first = 1'b0;
    word_data = '0; word_valid = 1'b0;
    repeat (3) @(negedge clk);
    // reset state: R8 R10
    chk(busy == 1'b0, "R8 reset busy", busy, 0);
    chk(ir_out == 1'b0, "R6 reset level", ir_out, 0);
    chk(word_ready == 1'b0, "R10 ready low while disabled", word_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);

    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 3; l++)
        for (int inv = 0; inv < 2; inv++)
          for (int f = 0; f < 4; f++) begin
            car_high         = CW'(h);
            car_low          = CW'(l);
            invert           = inv[0];
            one_space_first  = f[0];
            zero_space_first = f[1];
            one_mark   = MW'((h + f) % 3);             // 0 exercises R11
            one_space  = SW'(1 + (l % 2));
            zero_mark  = MW'(1 + (f % 2) * 2);
            zero_space = (f == 3) ? SW'(0) : SW'(2);   // R11
            @(negedge clk);
            chk(ir_out == invert, "R6 idle polarity", ir_out, invert);
            run_pair(WW'(h*5 + l*3 + f + inv*7), WW'(~(h*5 + l*3 + f) ^ inv));
          end

    // R10: drop enable mid-word
    invert = 1'b1; car_high = 4'd2; car_low = 4'd1;
    one_mark = 4'd2; one_space = 3'd2; zero_mark = 4'd2; zero_space = 3'd2;
    word_data = 4'hA; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R8 busy before disable", busy, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy clears on disable", busy, 0);
    chk(ir_out == 1'b1, "R10 idle level on disable", ir_out, 1);
    chk(word_ready == 1'b0, "R10 ready low on disable", word_ready, 0);
    word_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 no accept while disabled", busy, 0);
    word_valid = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    chk(word_ready == 1'b1, "R10 ready after re-enable", word_ready, 1);
    invert = 1'b0;
    run_pair(4'h9, 4'h6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule